// File: doc/BRIEF.md
# USB Bridge Slave-FIFO Master

This block drives the slave-FIFO side of an external USB bridge chip, with the FPGA as the only party that starts a transfer. Internal logic sees two streams. The transmit stream carries 16-bit words with valid/ready and an end-of-packet marker. The receive stream delivers 16-bit words with valid/ready. On the device side the block drives the read strobe, the write strobe, the output enable, a two-bit endpoint address and a packet-end line. All of these are active low. It watches the active-low full and empty flags and shares one bidirectional 16-bit data bus between both directions.

A small controller picks a direction. It sets up the endpoint address and performs the bus turnaround. It then moves a burst of words, one per clock, for as long as the flag and the user stream both allow. Receive traffic is served first when both sides are pending. After that the two directions take turns burst by burst, so neither side starves. When a transmit word is marked as the end of a packet, the packet-end line pulses once after that word is written. This commits a short packet to the host.

Top module: `usbFifoMaster`

## Requirements
- R1: While reset is held and in the first cycle after it, the read strobe, write strobe, output enable and packet-end line are all high (inactive), and both txReady and rxValid are low.
- R2: The write strobe goes low only when devFullN is high and txValid is high. txReady is high in exactly those cycles. The word on devData while the strobe is low equals txData.
- R3: The read strobe goes low only when devEmptyN is high and rxReady is high. In each such cycle rxValid is high and rxData equals the word the bridge drives on devData. With rxReady low, no word is taken from the bridge.
- R4: Writes target endpoint address TX_EP (default 2'b10) and reads target RX_EP (default 2'b00). The address holds its value for at least one clock before any strobe and during the strobe.
- R5: The output enable goes low at least one clock before the first read strobe of a burst and stays low for the whole read burst.
- R6: The FPGA never drives devData while the output enable is low. After a read burst, at least two clocks pass between the last cycle of output enable low and the next write strobe.
- R7: When both directions are pending after reset, a read burst comes first. After that the directions alternate burst by burst while both stay pending.
- R8: A burst holds at most BURST_MAX words (default 4). After a burst at least one clock with no strobe passes before the next strobe.
- R9: When a word is written with txEnd high, devPktEndN is low for exactly one clock, in the cycle right after that write, and no strobe is active in that cycle.
- R10: While devFullN is low, a pending transmit word is held: txReady stays low and nothing is written. The same word is written once the flag returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the bridge interface |
| rstN | input | 1 | Active-low synchronous reset |
| txData | input | 16 | Transmit word from internal logic |
| txValid | input | 1 | Transmit word present |
| txEnd | input | 1 | Transmit word is the last of its packet |
| txReady | output | 1 | Transmit word accepted this cycle |
| rxData | output | 16 | Received word |
| rxValid | output | 1 | Received word present this cycle |
| rxReady | input | 1 | Internal logic can accept a received word |
| devData | inout | 16 | Shared bridge data bus |
| devRdN | output | 1 | Read strobe, active low |
| devWrN | output | 1 | Write strobe, active low |
| devOeN | output | 1 | Bridge output enable, active low |
| devAddr | output | 2 | Endpoint buffer select |
| devPktEndN | output | 1 | Packet commit pulse, active low |
| devFullN | input | 1 | Bridge write buffer full, active low |
| devEmptyN | input | 1 | Bridge read buffer empty, active low |

## Verification
A write-only packet of three words with an end marker checks the data, the address and where the commit pulse lands. A read-only run checks the receive path. A run with rxReady held low shows that a waiting consumer stops reads even though the empty flag reports data. A run with both directions loaded with six words shows the first choice, the alternation and the burst length, and proves the turnaround gap in both directions. A run with the full flag forced low shows that a word is held and not lost.

// File: rtl/usbFifoPkg.sv
package usbFifoPkg;
  localparam int EP_W = 2;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_SETUP,
    S_RD,
    S_WR_SETUP,
    S_WR,
    S_PKTEND
  } fifoState_t;

  // control-to-datapath strobes, all active high
  typedef struct packed {
    logic            driveEn;
    logic            oeAct;
    logic            rdAct;
    logic            wrAct;
    logic            pktEndAct;
    logic [EP_W-1:0] epAddr;
  } busCtrl_t;
endpackage

// File: rtl/usbFifoCtrl.sv
module usbFifoCtrl
  import usbFifoPkg::*;
#(
  parameter int              BURST_MAX = 4,
  parameter logic [EP_W-1:0] TX_EP     = 2'b10,
  parameter logic [EP_W-1:0] RX_EP     = 2'b00
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     txValid,
  input  logic     txEnd,
  input  logic     rxReady,
  input  logic     fullN,
  input  logic     emptyN,
  output busCtrl_t ctrl
);
  localparam int CNT_W = $clog2(BURST_MAX + 1);

  fifoState_t      state, stateNext;
  logic [CNT_W-1:0] burstCnt;
  logic [EP_W-1:0] addrQ, addrNext;
  logic            lastWasRead;
  logic            rxPend, txPend, rdFire, wrFire, lastBeat;

  always_comb begin
    rxPend   = emptyN && rxReady;
    txPend   = txValid && fullN;
    rdFire   = (state == S_RD) && rxPend;
    wrFire   = (state == S_WR) && txPend;
    lastBeat = (burstCnt == CNT_W'(BURST_MAX - 1));
    stateNext = state;
    addrNext  = addrQ;
    case (state)
      S_IDLE: begin
        if (rxPend && (!txPend || !lastWasRead)) begin
          stateNext = S_RD_SETUP;
          addrNext  = RX_EP;
        end else if (txPend) begin
          stateNext = S_WR_SETUP;
          addrNext  = TX_EP;
        end
      end
      S_RD_SETUP: stateNext = S_RD;
      S_RD:       if (!rdFire || lastBeat) stateNext = S_IDLE;
      S_WR_SETUP: stateNext = S_WR;
      S_WR: begin
        if (wrFire && txEnd)           stateNext = S_PKTEND;
        else if (!wrFire || lastBeat)  stateNext = S_IDLE;
      end
      S_PKTEND:   stateNext = S_IDLE;
      default:    stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= S_IDLE;
      addrQ       <= RX_EP;
      burstCnt    <= '0;
      lastWasRead <= 1'b0;
    end else begin
      state <= stateNext;
      addrQ <= addrNext;
      if (stateNext == S_IDLE)      burstCnt <= '0;
      else if (rdFire || wrFire)    burstCnt <= burstCnt + 1'b1;
      if (state == S_RD && stateNext == S_IDLE) lastWasRead <= 1'b1;
      if (state == S_WR && stateNext != S_WR)   lastWasRead <= 1'b0;
    end
  end

  always_comb begin
    ctrl.driveEn   = (state == S_WR_SETUP) || (state == S_WR);
    ctrl.oeAct     = (state == S_RD_SETUP) || (state == S_RD);
    ctrl.rdAct     = rdFire;
    ctrl.wrAct     = wrFire;
    ctrl.pktEndAct = (state == S_PKTEND);
    ctrl.epAddr    = addrQ;
  end
endmodule

// File: rtl/usbFifoDatapath.sv
module usbFifoDatapath
  import usbFifoPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  busCtrl_t          ctrl,
  input  logic [DATA_W-1:0] txData,
  output logic              txReady,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  inout  wire  [DATA_W-1:0] devData,
  output logic              devRdN,
  output logic              devWrN,
  output logic              devOeN,
  output logic [EP_W-1:0]   devAddr,
  output logic              devPktEndN,
  output logic              busDrive
);
  assign devData    = ctrl.driveEn ? txData : {DATA_W{1'bz}};
  assign busDrive   = ctrl.driveEn;
  assign rxData     = devData;
  assign rxValid    = ctrl.rdAct;
  assign txReady    = ctrl.wrAct;
  assign devRdN     = ~ctrl.rdAct;
  assign devWrN     = ~ctrl.wrAct;
  assign devOeN     = ~ctrl.oeAct;
  assign devPktEndN = ~ctrl.pktEndAct;
  assign devAddr    = ctrl.epAddr;
endmodule

// File: rtl/usbFifoMaster.sv
module usbFifoMaster
  import usbFifoPkg::*;
#(
  parameter int              DATA_W    = 16,
  parameter int              BURST_MAX = 4,
  parameter logic [EP_W-1:0] TX_EP     = 2'b10,
  parameter logic [EP_W-1:0] RX_EP     = 2'b00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] txData,
  input  logic              txValid,
  input  logic              txEnd,
  output logic              txReady,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  input  logic              rxReady,
  inout  wire  [DATA_W-1:0] devData,
  output logic              devRdN,
  output logic              devWrN,
  output logic              devOeN,
  output logic [EP_W-1:0]   devAddr,
  output logic              devPktEndN,
  input  logic              devFullN,
  input  logic              devEmptyN
);
  busCtrl_t ctrl;
  logic     busDrive;

  usbFifoCtrl #(.BURST_MAX(BURST_MAX), .TX_EP(TX_EP), .RX_EP(RX_EP)) uCtrl (
    .clk(clk), .rstN(rstN), .txValid(txValid), .txEnd(txEnd),
    .rxReady(rxReady), .fullN(devFullN), .emptyN(devEmptyN), .ctrl(ctrl)
  );

  usbFifoDatapath #(.DATA_W(DATA_W)) uPath (
    .ctrl(ctrl), .txData(txData), .txReady(txReady), .rxData(rxData),
    .rxValid(rxValid), .devData(devData), .devRdN(devRdN), .devWrN(devWrN),
    .devOeN(devOeN), .devAddr(devAddr), .devPktEndN(devPktEndN),
    .busDrive(busDrive)
  );
endmodule

// File: rtl/usbFifoChk.sv
module usbFifoChk (
  input logic       clk,
  input logic       rstN,
  input logic       devRdN,
  input logic       devWrN,
  input logic       devOeN,
  input logic [1:0] devAddr,
  input logic       devPktEndN,
  input logic       devFullN,
  input logic       devEmptyN,
  input logic       rxReady,
  input logic       busDrive
);
  AST_WR_NOT_FULL: assert property (@(posedge clk) disable iff (!rstN)
    !devWrN |-> devFullN); // R2
  AST_RD_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    !devRdN |-> (devEmptyN && rxReady)); // R3
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!devRdN || !devWrN) |-> $stable(devAddr)); // R4
  AST_OE_LEADS_RD: assert property (@(posedge clk) disable iff (!rstN)
    !devRdN |-> (!devOeN && !$past(devOeN))); // R5
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rstN)
    !devOeN |-> !busDrive); // R6
  AST_DRIVE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busDrive) |-> $past(devOeN)); // R6
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !(!devRdN && !devWrN)); // R8
  AST_PKTEND_AFTER_WR: assert property (@(posedge clk) disable iff (!rstN)
    !devPktEndN |-> ($past(!devWrN) && devWrN && devRdN)); // R9
  AST_PKTEND_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    !devPktEndN |=> devPktEndN); // R9
endmodule

bind usbFifoMaster usbFifoChk uChk (
  .clk(clk), .rstN(rstN), .devRdN(devRdN), .devWrN(devWrN), .devOeN(devOeN),
  .devAddr(devAddr), .devPktEndN(devPktEndN), .devFullN(devFullN),
  .devEmptyN(devEmptyN), .rxReady(rxReady), .busDrive(busDrive)
);

// File: tb/tb_usbFifoMaster.sv
`timescale 1ns/1ps
module tb_usbFifoMaster;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] txData = '0;
  logic        txValid = 1'b0, txEnd = 1'b0, rxReady = 1'b0;
  logic        txReady, rxValid;
  logic [15:0] rxData;
  wire  [15:0] devData;
  logic        devRdN, devWrN, devOeN, devPktEndN;
  logic [1:0]  devAddr;
  logic        devFullN, devEmptyN;

  int checks = 0, fails = 0;

  // bridge model controls
  logic        mdlClear = 1'b1;
  logic [15:0] preloadN = '0;
  logic        forceFull = 1'b0;

  // bridge model state
  int          cyc = 0;
  logic [15:0] rxHead, rxTail;
  logic [15:0] txMem [0:63];
  int          txCnt, opCnt, pktCnt, pktWrites, pktGap, badOe, badGap;
  int          lastOeLow, lastWrCyc;
  logic        prevOeLow;
  logic        opRead [0:63];
  logic [1:0]  opAddr [0:63];
  int          opCycle [0:63];

  // receive monitor
  logic [15:0] rxGot [0:63];
  int          rxCnt = 0;

  always #2.5 clk = ~clk;

  usbFifoMaster dut (
    .clk(clk), .rstN(rstN), .txData(txData), .txValid(txValid), .txEnd(txEnd),
    .txReady(txReady), .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady),
    .devData(devData), .devRdN(devRdN), .devWrN(devWrN), .devOeN(devOeN),
    .devAddr(devAddr), .devPktEndN(devPktEndN), .devFullN(devFullN),
    .devEmptyN(devEmptyN)
  );

  assign devEmptyN = (rxHead != rxTail);
  assign devFullN  = !forceFull;
  assign devData   = !devOeN ? (16'h5000 + rxHead) : 16'hzzzz;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mdlClear) begin
      rxHead <= '0; rxTail <= preloadN; txCnt <= 0; opCnt <= 0; pktCnt <= 0;
      pktWrites <= 0; pktGap <= 0; badOe <= 0; badGap <= 0;
      lastOeLow <= -100; lastWrCyc <= -100; prevOeLow <= 1'b0;
    end else begin
      if (!devOeN) lastOeLow <= cyc;
      if (!devRdN) begin
        rxHead <= rxHead + 1'b1;
        if (!prevOeLow) badOe <= badOe + 1;
        opRead[opCnt[5:0]]  <= 1'b1;
        opAddr[opCnt[5:0]]  <= devAddr;
        opCycle[opCnt[5:0]] <= cyc;
        opCnt <= opCnt + 1;
      end
      if (!devWrN) begin
        txMem[txCnt[5:0]] <= devData;
        txCnt <= txCnt + 1;
        if (cyc - lastOeLow < 2) badGap <= badGap + 1;
        lastWrCyc <= cyc;
        opRead[opCnt[5:0]]  <= 1'b0;
        opAddr[opCnt[5:0]]  <= devAddr;
        opCycle[opCnt[5:0]] <= cyc;
        opCnt <= opCnt + 1;
      end
      if (!devPktEndN) begin
        pktCnt    <= pktCnt + 1;
        pktWrites <= txCnt;
        pktGap    <= cyc - lastWrCyc;
      end
      prevOeLow <= !devOeN;
    end
  end

  always begin
    @(negedge clk);
    #2;
    if (mdlClear) rxCnt = 0;
    else if (rxValid && rxReady) begin
      rxGot[rxCnt[5:0]] = rxData;
      rxCnt = rxCnt + 1;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic startReset(logic [15:0] pre);
    rstN = 1'b0; mdlClear = 1'b1; preloadN = pre; forceFull = 1'b0;
  endtask

  task automatic endReset();
    repeat (3) @(negedge clk);
    mdlClear = 1'b0; rstN = 1'b1;
  endtask

  task automatic sendWords(int n, bit endLast);
    for (int i = 0; i < n; i++) begin
      logic fired;
      txData  = 16'hA000 + 16'(i);
      txValid = 1'b1;
      txEnd   = endLast && (i == n - 1);
      do begin
        #2 fired = txReady;
        @(negedge clk);
      end while (!fired);
    end
    txValid = 1'b0; txEnd = 1'b0;
  endtask

  task automatic testReset();
    @(negedge clk);
    startReset(16'd0);
    repeat (2) @(negedge clk);
    chk("R1 rdN", 32'(devRdN), 1);
    chk("R1 wrN", 32'(devWrN), 1);
    chk("R1 oeN", 32'(devOeN), 1);
    chk("R1 pktEndN", 32'(devPktEndN), 1);
    chk("R1 txReady", 32'(txReady), 0);
    chk("R1 rxValid", 32'(rxValid), 0);
    endReset();
    chk("R1 wrN after release", 32'(devWrN), 1);
  endtask

  task automatic testWritePacket();
    @(negedge clk);
    startReset(16'd0); rxReady = 1'b0;
    endReset();
    sendWords(3, 1'b1);
    repeat (6) @(negedge clk);
    chk("R2 write count", 32'(txCnt), 3);
    for (int i = 0; i < 3; i++) begin
      chk("R2 write data", 32'(txMem[i]), 32'(16'hA000 + 16'(i)));
      chk("R4 write endpoint", 32'(opAddr[i]), 2);
    end
    chk("R9 pkt pulses", 32'(pktCnt), 1);
    chk("R9 words before commit", 32'(pktWrites), 3);
    chk("R9 commit one cycle after write", 32'(pktGap), 1);
  endtask

  task automatic testRead();
    @(negedge clk);
    startReset(16'd3); rxReady = 1'b1;
    endReset();
    repeat (12) @(negedge clk);
    chk("R3 read count", 32'(rxCnt), 3);
    for (int i = 0; i < 3; i++) begin
      chk("R3 read data", 32'(rxGot[i]), 32'(16'h5000 + 16'(i)));
      chk("R4 read endpoint", 32'(opAddr[i]), 0);
    end
    chk("R5 oe before each read", 32'(badOe), 0);
  endtask

  task automatic testRxHold();
    @(negedge clk);
    startReset(16'd2); rxReady = 1'b0;
    endReset();
    repeat (8) @(negedge clk);
    chk("R3 no read while rxReady low", 32'(opCnt), 0);
    chk("R3 rdN idle", 32'(devRdN), 1);
    rxReady = 1'b1;
    repeat (8) @(negedge clk);
    chk("R3 reads after rxReady", 32'(rxCnt), 2);
    chk("R3 first word kept", 32'(rxGot[0]), 32'h5000);
  endtask

  task automatic testArbitration();
    int expKind [12] = '{1,1,1,1,0,0,0,0,1,1,0,0};
    @(negedge clk);
    rxReady = 1'b1;
    startReset(16'd6);
    fork sendWords(6, 1'b0); join_none
    endReset();
    repeat (40) @(negedge clk);
    chk("R7 op count", 32'(opCnt), 12);
    for (int i = 0; i < 12; i++)
      chk("R7 R8 op order", 32'(opRead[i]), 32'(expKind[i]));
    chk("R8 gap after first burst", 32'((opCycle[4] - opCycle[3]) >= 2), 1);
    chk("R6 turnaround gap", 32'(badGap), 0);
    chk("R5 oe lead", 32'(badOe), 0);
    for (int i = 0; i < 6; i++) begin
      chk("R7 tx data", 32'(txMem[i]), 32'(16'hA000 + 16'(i)));
      chk("R7 rx data", 32'(rxGot[i]), 32'(16'h5000 + 16'(i)));
    end
  endtask

  task automatic testFull();
    @(negedge clk);
    startReset(16'd0); rxReady = 1'b0;
    endReset();
    forceFull = 1'b1;
    txData = 16'hBEEF; txValid = 1'b1; txEnd = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      #1;
      chk("R10 txReady held low", 32'(txReady), 0);
    end
    chk("R10 nothing written", 32'(txCnt), 0);
    @(negedge clk);
    forceFull = 1'b0;
    #2 while (!txReady) begin @(negedge clk); #2; end
    @(negedge clk);
    txValid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 one write after release", 32'(txCnt), 1);
    chk("R10 held word", 32'(txMem[0]), 32'hBEEF);
  endtask

  initial begin
    testReset();
    testWritePacket();
    testRead();
    testRxHold();
    testArbitration();
    testFull();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(100000 * 5);
    checks++; fails++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule